// File: doc/BRIEF.md
# UART Receive Queue with Level Request

This block is the receive queue of a serial port. Entries reach it from the deserializer or from the internal loopback path. Each entry holds eight data bits plus four error flags placed above them. The other side of the queue serves data-register reads from the system bus. It keeps empty and full flags for software to poll. It raises a receive-level request when the stored count reaches a trigger level. Each time an entry is read, its error flags are copied into a status register.

A mode input picks between two forms of the queue. One is full-depth buffering, 16 entries by default. The other is a single holding register, for software that handles one byte at a time. Any change of the mode input flushes the queue. A received line break is stored as its own entry: data bits zero and the break flag set. If an entry arrives while the queue is full, it is dropped and an overrun pulse is raised in its place.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `full`=0, `rx_req`=0, `rx_status`=0, `overrun`=0.
- R2: With `fifo_en`=1 the queue holds `DEPTH` entries and returns them in arrival order. `full` rises when the count reaches `DEPTH`. A push and a pop in the same cycle leave the count unchanged.
- R3: With `fifo_en`=0 the queue holds one entry and always reads from and writes to slot 0, so `full` is 1 after a single push.
- R4: A push while `full` is 1 is refused, and the stored entries stay unchanged. `overrun` is 1 for the cycle after each refused push.
- R5: `rx_req` is set when an accepted push brings the count to the trigger level, which is fixed at 1.
- R6: `rx_req` is cleared when an accepted pop brings the count to trigger-1 (0). Otherwise it holds its value.
- R7: An accepted pop copies bits [11:8] of the entry it removes into `rx_status`. A `stat_clr` pulse clears `rx_status`. If both happen in the same cycle, the pop wins.
- R8: A pop while the queue is empty changes nothing. `empty`, `rx_status` and `rd_entry` keep their values, and `rd_entry` keeps showing the slot at the read position.
- R9: A cycle in which `fifo_en` differs from its previous value flushes the queue. The count and read position go to zero, `empty`=1 and `full`=0, and any push or pop in that cycle is ignored.
- R10: A `push_break` stores the entry 0x400. That is break flag bit 10 set (status bit 2), data zero, and no other error bit. It takes precedence over `push_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 selects full-depth buffering, 0 selects a single holding register |
| push_valid | input | 1 | Store one received entry |
| push_data | input | 8 | Received data byte |
| push_err | input | 4 | Error flags of the received entry, stored as entry bits [11:8] |
| push_break | input | 1 | Store a break entry (0x400) |
| pop | input | 1 | Data-register read: remove the entry at the head |
| stat_clr | input | 1 | Write to the status register: clear it |
| rd_entry | output | 12 | Entry at the read position, error flags in [11:8] |
| rx_status | output | 4 | Error flags of the last entry popped |
| empty | output | 1 | Queue holds no entry |
| full | output | 1 | Queue holds its effective depth |
| rx_req | output | 1 | Receive-level request |
| overrun | output | 1 | One-cycle pulse after a refused push |

## Verification
The bench fills the deep queue from a read position that is not zero, so the write slot has to wrap. A design that forgot the mask on the write slot would return the entries out of order. It pushes into a full queue: a design that overwrote the tail would change the data later read back, and one that did not flag the loss would never pulse `overrun`. It pops an empty single-entry queue after clearing the status. A design that latched status on every read, or moved the read position on an empty read, would show nonzero status or a different `rd_entry`. It also toggles the mode while a push is pending, and checks a pop and a status clear in the same cycle. A design that let the push through the flush would end up non-empty, and one that gave the clear priority would lose the popped flags.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
   localparam int DATA_W  = 8;
   localparam int ERR_W   = 4;
   localparam int ENTRY_W = DATA_W + ERR_W;
   // index of the break flag inside the error field (entry bit 10)
   localparam int BRK_IDX = 2;

   typedef struct packed {
      logic [ERR_W-1:0]  err;
      logic [DATA_W-1:0] data;
   } rxq_entry_t;
endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store
   import uart_rxq_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PTR_W-1:0] wr_idx,
   input  rxq_entry_t       wr_ent,
   input  logic [PTR_W-1:0] rd_idx,
   output rxq_entry_t       rd_ent
);
   rxq_entry_t slot_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[g] <= '0;
         end else if (wr_en && (wr_idx == PTR_W'(g))) begin
            slot_q[g] <= wr_ent;
         end
      end
   end

   assign rd_ent = slot_q[rd_idx];
endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl #(
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic             push_req,
   input  logic             pop_req,
   output logic             push_ok,
   output logic             pop_ok,
   output logic             refused,
   output logic [PTR_W-1:0] wr_idx,
   output logic [PTR_W-1:0] rd_idx,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             empty,
   output logic             full
);
   logic [CNT_W-1:0] count_q;
   logic [PTR_W-1:0] pos_q, pos_nxt;
   logic             en_q;
   logic             flush;
   logic             at_cap;
   logic [CNT_W-1:0] depth_eff;
   logic [PTR_W-1:0] mask;

   assign depth_eff = en_q ? CNT_W'(DEPTH) : CNT_W'(1);
   assign mask      = en_q ? PTR_W'(DEPTH - 1) : '0;
   assign flush     = fifo_en ^ en_q;
   assign at_cap    = (count_q == depth_eff);

   assign push_ok = push_req && !flush && !at_cap;
   assign refused = push_req && !flush && at_cap;
   assign pop_ok  = pop_req && !flush && (count_q != '0);

   always_comb begin
      cnt_nxt = count_q;
      pos_nxt = pos_q;
      if (flush) begin
         cnt_nxt = '0;
         pos_nxt = '0;
      end else begin
         if (push_ok && !pop_ok) cnt_nxt = count_q + CNT_W'(1);
         if (pop_ok && !push_ok) cnt_nxt = count_q - CNT_W'(1);
         if (pop_ok)             pos_nxt = (pos_q + PTR_W'(1)) & mask;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         pos_q   <= '0;
         en_q    <= 1'b0;
      end else begin
         count_q <= cnt_nxt;
         pos_q   <= pos_nxt;
         en_q    <= fifo_en;
      end
   end

   assign wr_idx = (pos_q + count_q[PTR_W-1:0]) & mask;
   assign rd_idx = pos_q;
   assign empty  = (count_q == '0);
   assign full   = at_cap;
endmodule

// File: rtl/uart_rxq_irq.sv
module uart_rxq_irq
   import uart_rxq_pkg::*;
#(
   parameter int TRIG_LEVEL = 1,
   parameter int CNT_W      = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_ok,
   input  logic             pop_ok,
   input  logic             refused,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic [ERR_W-1:0] pop_err,
   input  logic             stat_clr,
   output logic             rx_req,
   output logic [ERR_W-1:0] rx_status,
   output logic             overrun
);
   localparam logic [CNT_W-1:0] SET_AT = CNT_W'(TRIG_LEVEL);
   localparam logic [CNT_W-1:0] CLR_AT = CNT_W'(TRIG_LEVEL - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_req    <= 1'b0;
         rx_status <= '0;
         overrun   <= 1'b0;
      end else begin
         if (push_ok && (cnt_nxt == SET_AT)) begin
            rx_req <= 1'b1;
         end else if (pop_ok && (cnt_nxt == CLR_AT)) begin
            rx_req <= 1'b0;
         end
         if (pop_ok) begin
            rx_status <= pop_err;
         end else if (stat_clr) begin
            rx_status <= '0;
         end
         overrun <= refused;
      end
   end
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
   import uart_rxq_pkg::*;
#(
   parameter int DEPTH      = 16,
   parameter int TRIG_LEVEL = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fifo_en,
   input  logic               push_valid,
   input  logic [DATA_W-1:0]  push_data,
   input  logic [ERR_W-1:0]   push_err,
   input  logic               push_break,
   input  logic               pop,
   input  logic               stat_clr,
   output logic [ENTRY_W-1:0] rd_entry,
   output logic [ERR_W-1:0]   rx_status,
   output logic               empty,
   output logic               full,
   output logic               rx_req,
   output logic               overrun
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uart_rx_queue: DEPTH must be a power of two of at least 2");
   end
   if (TRIG_LEVEL < 1 || TRIG_LEVEL > DEPTH) begin : g_bad_trig
      $error("uart_rx_queue: TRIG_LEVEL must lie in 1..DEPTH");
   end

   rxq_entry_t       in_ent, head_ent;
   logic             push_req;
   logic             push_ok, pop_ok, refused;
   logic [PTR_W-1:0] wr_idx, rd_idx;
   logic [CNT_W-1:0] cnt_nxt;

   always_comb begin
      push_req = push_valid || push_break;
      if (push_break) begin
         in_ent = '0;
         in_ent.err[BRK_IDX] = 1'b1;
      end else begin
         in_ent.err  = push_err;
         in_ent.data = push_data;
      end
   end

   uart_rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .fifo_en  (fifo_en),
      .push_req (push_req),
      .pop_req  (pop),
      .push_ok  (push_ok),
      .pop_ok   (pop_ok),
      .refused  (refused),
      .wr_idx   (wr_idx),
      .rd_idx   (rd_idx),
      .cnt_nxt  (cnt_nxt),
      .empty    (empty),
      .full     (full)
   );

   uart_rxq_store #(.DEPTH(DEPTH)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (push_ok),
      .wr_idx (wr_idx),
      .wr_ent (in_ent),
      .rd_idx (rd_idx),
      .rd_ent (head_ent)
   );

   uart_rxq_irq #(.TRIG_LEVEL(TRIG_LEVEL), .CNT_W(CNT_W)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_ok   (push_ok),
      .pop_ok    (pop_ok),
      .refused   (refused),
      .cnt_nxt   (cnt_nxt),
      .pop_err   (head_ent.err),
      .stat_clr  (stat_clr),
      .rx_req    (rx_req),
      .rx_status (rx_status),
      .overrun   (overrun)
   );

   assign rd_entry = head_ent;
endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk
   import uart_rxq_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             push_valid,
   input logic             push_break,
   input logic             pop,
   input logic             stat_clr,
   input logic [ERR_W-1:0] rx_status,
   input logic             empty,
   input logic             full,
   input logic             rx_req,
   input logic             overrun
);
   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(empty && full)); // R2
   AST_OVERRUN_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> $past(full)); // R4
   AST_REQ_RISE_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_req) |-> $past(push_valid || push_break)); // R5
   AST_REQ_FALL_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_req) |-> $past(pop)); // R6
   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!pop && !stat_clr) |=> $stable(rx_status)); // R7
   AST_EMPTY_POP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push_valid && !push_break) |=> empty); // R8
endmodule

bind uart_rx_queue uart_rx_queue_chk u_chk (.*);

// File: tb/uart_rx_queue_bench.sv
module uart_rx_queue_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fifo_en = 1'b0;
   logic        push_valid = 1'b0;
   logic [7:0]  push_data = '0;
   logic [3:0]  push_err = '0;
   logic        push_break = 1'b0;
   logic        pop = 1'b0;
   logic        stat_clr = 1'b0;
   logic [11:0] rd_entry;
   logic [3:0]  rx_status;
   logic        empty, full, rx_req, overrun;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   uart_rx_queue u_uart_rx_queue (.*);

   typedef struct packed {
      logic        push;
      logic [11:0] din;
      logic        pop;
      logic        e_empty;
      logic        e_full;
      logic        e_req;
      logic [11:0] e_rd;
      logic [3:0]  e_stat;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{1'b1, 12'h041, 1'b0, 1'b0, 1'b0, 1'b1, 12'h041, 4'h0},
      '{1'b1, 12'h142, 1'b0, 1'b0, 1'b0, 1'b1, 12'h041, 4'h0},
      '{1'b0, 12'h000, 1'b1, 1'b0, 1'b0, 1'b1, 12'h142, 4'h0},
      '{1'b0, 12'h000, 1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 4'h1},
      '{1'b1, 12'h843, 1'b1, 1'b0, 1'b0, 1'b1, 12'h843, 4'h1},
      '{1'b0, 12'h000, 1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 4'h8}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step;
      @(posedge clk);
      #1;
   endtask

   task automatic idle_in;
      push_valid = 1'b0;
      push_break = 1'b0;
      pop        = 1'b0;
      stat_clr   = 1'b0;
   endtask

   task automatic do_push(input logic [11:0] e);
      push_valid = 1'b1;
      push_data  = e[7:0];
      push_err   = e[11:8];
      step();
      idle_in();
   endtask

   task automatic do_pop;
      pop = 1'b1;
      step();
      idle_in();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      chk("R1 empty", 16'(empty), 16'h1);
      chk("R1 full", 16'(full), 16'h0);
      chk("R1 req", 16'(rx_req), 16'h0);
      chk("R1 status", 16'(rx_status), 16'h0);
      chk("R1 overrun", 16'(overrun), 16'h0);

      fifo_en = 1'b1;
      step();
      chk("R9 enable flush empty", 16'(empty), 16'h1);

      // table walk: R2 order, R5 set, R6 clear, R7 status latch
      foreach (VEC[i]) begin
         push_valid = VEC[i].push;
         push_data  = VEC[i].din[7:0];
         push_err   = VEC[i].din[11:8];
         pop        = VEC[i].pop;
         step();
         idle_in();
         chk($sformatf("R2 vec%0d empty", i), 16'(empty), 16'(VEC[i].e_empty));
         chk($sformatf("R2 vec%0d full", i), 16'(full), 16'(VEC[i].e_full));
         chk($sformatf("R5/R6 vec%0d req", i), 16'(rx_req), 16'(VEC[i].e_req));
         chk($sformatf("R2 vec%0d rd_entry", i), 16'(rd_entry), 16'(VEC[i].e_rd));
         chk($sformatf("R7 vec%0d status", i), 16'(rx_status), 16'(VEC[i].e_stat));
      end

      // R2 fill from read position 3 (write slot wraps), R4 overrun
      for (int k = 0; k < 16; k++) begin
         do_push(12'(k + 8'h20));
         chk("R2 not full before depth", 16'(full), 16'(k == 15));
      end
      chk("R5 req with data", 16'(rx_req), 16'h1);
      do_push(12'h0FF);
      chk("R4 overrun pulse", 16'(overrun), 16'h1);
      chk("R4 still full", 16'(full), 16'h1);
      step();
      chk("R4 overrun one cycle", 16'(overrun), 16'h0);
      for (int k = 0; k < 16; k++) begin
         chk("R2 order / R4 content kept", 16'(rd_entry), 16'(k + 8'h20));
         do_pop();
         chk("R6 req held until last pop", 16'(rx_req), 16'(k != 15));
      end
      chk("R2 empty after drain", 16'(empty), 16'h1);

      // R7 status clear and priority
      do_push(12'h9AA);
      do_pop();
      chk("R7 status from pop", 16'(rx_status), 16'h9);
      stat_clr = 1'b1;
      step();
      idle_in();
      chk("R7 status clear", 16'(rx_status), 16'h0);
      do_push(12'h355);
      pop = 1'b1;
      stat_clr = 1'b1;
      step();
      idle_in();
      chk("R7 pop beats clear", 16'(rx_status), 16'h3);

      // R10 break entry
      push_break = 1'b1;
      push_valid = 1'b1;
      push_data  = 8'h77;
      push_err   = 4'h1;
      step();
      idle_in();
      chk("R10 break entry", 16'(rd_entry), 16'h400);
      do_pop();
      chk("R10 break status", 16'(rx_status), 16'h4);

      // R9 flush on mode change with a push pending
      do_push(12'h011);
      do_push(12'h022);
      fifo_en = 1'b0;
      push_valid = 1'b1;
      push_data = 8'h33;
      push_err = 4'h0;
      step();
      idle_in();
      chk("R9 flush empty", 16'(empty), 16'h1);
      chk("R9 flush full", 16'(full), 16'h0);

      // R3 single holding register
      do_push(12'h1A5);
      chk("R3 full after one", 16'(full), 16'h1);
      do_push(12'h066);
      chk("R4 single overrun", 16'(overrun), 16'h1);
      chk("R3 entry kept", 16'(rd_entry), 16'h1A5);
      do_pop();
      chk("R3 empty after pop", 16'(empty), 16'h1);
      chk("R6 single req clear", 16'(rx_req), 16'h0);
      chk("R7 single status", 16'(rx_status), 16'h1);
      chk("R3 slot 0 kept", 16'(rd_entry), 16'h1A5);
      stat_clr = 1'b1;
      step();
      idle_in();
      // R8 pop on empty changes nothing
      do_pop();
      chk("R8 status unchanged", 16'(rx_status), 16'h0);
      chk("R8 still empty", 16'(empty), 16'h1);
      chk("R8 rd_entry unchanged", 16'(rd_entry), 16'h1A5);
      chk("R8 req unchanged", 16'(rx_req), 16'h0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule